// File: doc/BRIEF.md
# PWM Generator with Dead-Band and Trip

This block produces one pair of pulse-width modulated outputs from a 16-bit time-base counter. The counter can count up, count down, or count up and then down. A period register sets the PWM frequency. Two compare registers mark points inside each period. The counter's zero, period and compare matches form six events. For each output, a separate 2-bit action chooses what every event does to that output.

Between the raw action outputs and the pins there are three further stages:

- An optional dead-band stage turns output A into a complementary pair. A gets its own rising-edge delay, and B is the inverted A with its own delay on A's falling edge.
- An optional chopper ANDs the active level with a divided carrier.
- A trip override forces both pins low as soon as the trip input is high, without waiting for a clock edge. In latched mode the override stays in force until software clears it.

The block also emits a one-cycle interrupt pulse and a one-cycle ADC start-of-conversion pulse, each on a selectable event. A plain register write port configures the block. There is no read path and no streaming interface. Period and compare writes go to shadow copies, which move into the working copies only at counter zero.

Register map:

| Address | Register | Contents |
|---|---|---|
| 0 | Period | Period value |
| 1 | Compare A | Compare A value |
| 2 | Compare B | Compare B value |
| 3 | Configuration | bits [1:0] count mode (0 up, 1 down, 2 up-down, 3 frozen); bit 2 run; bit 3 dead-band enable; bit 4 chopper enable; bit 5 latched trip |
| 4 | Action A | 2-bit field per event (see R3) |
| 5 | Action B | 2-bit field per event (see R3) |
| 6 | Rising delay | 10-bit cycle count |
| 7 | Falling delay | 10-bit cycle count |
| 8 | Event select | bits [2:0] interrupt source, bits [5:3] ADC source |
| 9 | Trip clear | Any write clears the trip latch |
| 10 | Carrier divider | Divider value |

Top module: `pwm_gen`

## Requirements
- R1: After reset, the counter is stopped at zero, and pwm_a, pwm_b, irq and adc_soc are all 0.
- R2: While run is set, the counter steps once per clock.
  - In up mode it counts 0..P and then returns to 0, so each period lasts P+1 cycles.
  - In down mode it counts from P down to 0 and then reloads, so each period lasts P+1 cycles.
  - In up-down mode it counts 0..P..0, so each period lasts 2P cycles (P at least 2).
  - When run is clear, the counter holds at zero.
- R3: The six events sit in the action register as 2-bit fields, in this order: zero [1:0], period [3:2], compare-A counting up [5:4], compare-A counting down [7:6], compare-B counting up [9:8], compare-B counting down [11:10].
  - Field code 0 does nothing, 1 clears the output, 2 sets it and 3 toggles it.
  - The raw output changes on the clock edge that ends the event cycle.
  - When several events fire in the same cycle, the field at the higher bit position wins.
- R4: In single-edge use (for example, set at zero and clear on the compare-up match), A follows compare A and B follows compare B independently. In up-down use (set on the up match, clear on the down match), each output is high for twice the distance from its compare value to the period.
- R5: An asymmetric pulse on A is produced by setting A on the compare-A up match and clearing it on the compare-B up match. A is then high for cmpB − cmpA cycles of each period.
- R6: Period and compare writes land in shadow registers. They move into the working registers on the clock edge that ends a cycle where the counter is zero, never in the middle of a period.
- R7: With dead-band enabled:
  - pwm_a is raw A with its rising edge delayed by the rising-delay count.
  - pwm_b is the inverse of raw A with its rising edge delayed by the falling-delay count.
  - The two outputs are never high together.
- R8: While trip_in is high, pwm_a and pwm_b are 0 in the same cycle, with no clock edge needed. In unlatched mode, the outputs return to normal as soon as trip_in falls.
- R9: In latched mode, a trip seen on a clock edge holds both outputs at 0 until a write to the trip-clear address.
- R10: With the chopper enabled, each output is ANDed with a carrier. The carrier toggles every D+1 clocks, where D is the carrier divider.
- R11: An event select code of 1..6 picks zero, period, compare-A up, compare-A down, compare-B up or compare-B down; code 0 picks nothing. irq and adc_soc pulse for one cycle, in the cycle after the selected event, and only while run is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| trip_in | input | 1 | Fault input, active high, asynchronous override |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| irq | output | 1 | Interrupt event pulse |
| adc_soc | output | 1 | ADC start-of-conversion pulse |

## Verification
The counter-range property assumes that software does not change the count mode while the counter runs, and that the period is at least 2 in up-down mode. The bench therefore clears run before it reprograms the mode, and it uses periods of 5 or more. The dead-band property assumes that the delay registers are programmed before dead-band is enabled. The trip properties expect trip_in to be driven between clock edges; the stimulus changes it only on falling edges. Event select codes stay within 0..6.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  localparam int NUM_EV = 6;
  localparam int ACTW   = 2 * NUM_EV;
  localparam int AW     = 4;

  typedef enum logic [1:0] {
    CNT_UP     = 2'd0,
    CNT_DOWN   = 2'd1,
    CNT_UPDOWN = 2'd2,
    CNT_FROZEN = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_CLR  = 2'd1,
    ACT_SET  = 2'd2,
    ACT_TGL  = 2'd3
  } act_e;

  typedef struct packed {
    logic      trip_latch;
    logic      chop_en;
    logic      db_en;
    logic      run;
    cnt_mode_e mode;
  } cfg_t;

  localparam logic [AW-1:0] ADDR_PRD     = 4'd0;
  localparam logic [AW-1:0] ADDR_CMPA    = 4'd1;
  localparam logic [AW-1:0] ADDR_CMPB    = 4'd2;
  localparam logic [AW-1:0] ADDR_CFG     = 4'd3;
  localparam logic [AW-1:0] ADDR_ACTA    = 4'd4;
  localparam logic [AW-1:0] ADDR_ACTB    = 4'd5;
  localparam logic [AW-1:0] ADDR_DBRISE  = 4'd6;
  localparam logic [AW-1:0] ADDR_DBFALL  = 4'd7;
  localparam logic [AW-1:0] ADDR_EVSEL   = 4'd8;
  localparam logic [AW-1:0] ADDR_TRIPCLR = 4'd9;
  localparam logic [AW-1:0] ADDR_CARRIER = 4'd10;
endpackage

// File: rtl/pwm_gen_timebase.sv
module pwm_gen_timebase
  import pwm_gen_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  cnt_mode_e         mode,
  input  logic [CW-1:0]     prd_shd,
  input  logic [CW-1:0]     cmpa_shd,
  input  logic [CW-1:0]     cmpb_shd,
  output logic [CW-1:0]     cnt,
  output logic [CW-1:0]     prd_act,
  output logic [CW-1:0]     cmpa_act,
  output logic [NUM_EV-1:0] ev
);
  logic [CW-1:0] cmpb_act;
  logic          up_q;
  logic          at_zero;

  assign at_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      up_q     <= 1'b1;
      prd_act  <= '0;
      cmpa_act <= '0;
      cmpb_act <= '0;
    end else begin
      if (at_zero) begin
        prd_act  <= prd_shd;
        cmpa_act <= cmpa_shd;
        cmpb_act <= cmpb_shd;
      end
      if (!run) begin
        cnt  <= '0;
        up_q <= (mode != CNT_DOWN);
      end else begin
        case (mode)
          CNT_UP: begin
            up_q <= 1'b1;
            cnt  <= (cnt == prd_act) ? '0 : cnt + CW'(1);
          end
          CNT_DOWN: begin
            up_q <= 1'b0;
            cnt  <= at_zero ? prd_shd : cnt - CW'(1);
          end
          CNT_UPDOWN: begin
            if (up_q) begin
              if (cnt == prd_act) begin
                cnt  <= cnt - CW'(1);
                up_q <= 1'b0;
              end else begin
                cnt <= cnt + CW'(1);
              end
            end else if (at_zero) begin
              cnt  <= CW'(1);
              up_q <= 1'b1;
            end else begin
              cnt <= cnt - CW'(1);
            end
          end
          default: cnt <= cnt;
        endcase
      end
    end
  end

  // Event order matches the action field order: zero, period, A up, A down, B up, B down
  always_comb begin
    ev = '0;
    if (run) begin
      ev[0] = at_zero;
      ev[1] = (cnt == prd_act);
      ev[2] = (cnt == cmpa_act) && up_q;
      ev[3] = (cnt == cmpa_act) && !up_q;
      ev[4] = (cnt == cmpb_act) && up_q;
      ev[5] = (cnt == cmpb_act) && !up_q;
    end
  end
endmodule

// File: rtl/pwm_gen_action.sv
module pwm_gen_action
  import pwm_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev,
  input  logic [ACTW-1:0]   act,
  output logic              q
);
  logic nxt;

  // Higher-numbered events are applied last and therefore win
  always_comb begin
    nxt = q;
    for (int i = 0; i < NUM_EV; i++) begin
      if (ev[i]) begin
        case (act_e'(act[2*i +: 2]))
          ACT_CLR: nxt = 1'b0;
          ACT_SET: nxt = 1'b1;
          ACT_TGL: nxt = ~nxt;
          default: nxt = nxt;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= nxt;
  end
endmodule

// File: rtl/pwm_gen_edge_delay.sv
module pwm_gen_edge_delay #(
  parameter int DBW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           x,
  input  logic [DBW-1:0] dly,
  output logic           y
);
  logic [DBW-1:0] held;

  // Counts how long x has been high, saturating at the programmed delay
  always_ff @(posedge clk) begin
    if (!rst_n || !x) held <= '0;
    else if (held < dly) held <= held + DBW'(1);
  end

  assign y = x && (held >= dly);
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_gen_pkg::*;
#(
  parameter int CW  = 16,
  parameter int DBW = 10,
  parameter int CHW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          trip_in,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic          irq,
  output logic          adc_soc
);
  localparam int CFGW = $bits(cfg_t);
  localparam int SELW = 3;

  logic [CW-1:0]            prd_shd, cmpa_shd, cmpb_shd;
  cfg_t                     cfg_q;
  logic [1:0][ACTW-1:0]     act_q;
  logic [1:0][DBW-1:0]      db_dly;
  logic [2*SELW-1:0]        evsel_q;
  logic [CHW-1:0]           cdiv_q, ccnt_q;
  logic                     carrier_q;
  logic                     trip_lat;
  logic                     trip_clr;

  logic [CW-1:0]            cnt, prd_act, cmpa_act;
  logic [NUM_EV-1:0]        ev;
  logic [1:0]               raw, db_x, db_out, pre, chopped;
  logic                     run, db_en, force_off;

  assign run      = cfg_q.run;
  assign db_en    = cfg_q.db_en;
  assign trip_clr = wr_en && (wr_addr == ADDR_TRIPCLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_shd  <= '0;
      cmpa_shd <= '0;
      cmpb_shd <= '0;
      cfg_q    <= '0;
      act_q    <= '0;
      db_dly   <= '0;
      evsel_q  <= '0;
      cdiv_q   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_PRD:     prd_shd   <= wr_data;
        ADDR_CMPA:    cmpa_shd  <= wr_data;
        ADDR_CMPB:    cmpb_shd  <= wr_data;
        ADDR_CFG:     cfg_q     <= cfg_t'(wr_data[CFGW-1:0]);
        ADDR_ACTA:    act_q[0]  <= wr_data[ACTW-1:0];
        ADDR_ACTB:    act_q[1]  <= wr_data[ACTW-1:0];
        ADDR_DBRISE:  db_dly[0] <= wr_data[DBW-1:0];
        ADDR_DBFALL:  db_dly[1] <= wr_data[DBW-1:0];
        ADDR_EVSEL:   evsel_q   <= wr_data[2*SELW-1:0];
        ADDR_CARRIER: cdiv_q    <= wr_data[CHW-1:0];
        default: ;
      endcase
    end
  end

  pwm_gen_timebase #(.CW(CW)) u_tb (
    .clk, .rst_n, .run, .mode(cfg_q.mode),
    .prd_shd, .cmpa_shd, .cmpb_shd,
    .cnt, .prd_act, .cmpa_act, .ev
  );

  // One action unit and one edge-delay unit per output
  assign db_x = {~raw[0], raw[0]};

  for (genvar g = 0; g < 2; g++) begin : g_out
    pwm_gen_action u_act (
      .clk, .rst_n, .ev, .act(act_q[g]), .q(raw[g])
    );
    pwm_gen_edge_delay #(.DBW(DBW)) u_dly (
      .clk, .rst_n, .x(db_x[g]), .dly(db_dly[g]), .y(db_out[g])
    );
    assign pre[g]     = db_en ? db_out[g] : raw[g];
    assign chopped[g] = pre[g] && (!cfg_q.chop_en || carrier_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccnt_q    <= '0;
      carrier_q <= 1'b0;
    end else if (ccnt_q == cdiv_q) begin
      ccnt_q    <= '0;
      carrier_q <= ~carrier_q;
    end else begin
      ccnt_q <= ccnt_q + CHW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                            trip_lat <= 1'b0;
    else if (trip_in && cfg_q.trip_latch)  trip_lat <= 1'b1;
    else if (trip_clr)                     trip_lat <= 1'b0;
  end

  assign force_off = trip_in || trip_lat;
  assign pwm_a     = chopped[0] && !force_off;
  assign pwm_b     = chopped[1] && !force_off;

  function automatic logic pick(input logic [SELW-1:0] sel, input logic [NUM_EV-1:0] e);
    if (sel != '0 && int'(sel) <= NUM_EV) return e[sel - SELW'(1)];
    return 1'b0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      adc_soc <= 1'b0;
    end else begin
      irq     <= pick(evsel_q[SELW-1:0], ev);
      adc_soc <= pick(evsel_q[2*SELW-1:SELW], ev);
    end
  end
endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trip_in,
  input logic          trip_lat,
  input logic          pwm_a,
  input logic          pwm_b,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] prd_act,
  input logic [CW-1:0] cmpa_act,
  input logic          run,
  input logic          irq,
  input logic          db_en,
  input logic          db_a,
  input logic          db_b
);
  AST_TRIP_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    trip_in |-> (!pwm_a && !pwm_b)); // R8

  AST_LATCH_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    trip_lat |-> (!pwm_a && !pwm_b)); // R9

  AST_CNT_WITHIN_PRD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= prd_act); // R2

  AST_SHADOW_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmpa_act) |-> ($past(cnt) == '0)); // R6

  AST_DB_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    db_en |-> !(db_a && db_b)); // R7

  AST_IRQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(run)); // R11
endmodule

bind pwm_gen pwm_gen_chk #(.CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .trip_in(trip_in), .trip_lat(trip_lat),
  .pwm_a(pwm_a), .pwm_b(pwm_b), .cnt(cnt), .prd_act(prd_act),
  .cmpa_act(cmpa_act), .run(run), .irq(irq), .db_en(db_en),
  .db_a(db_out[0]), .db_b(db_out[1])
);

// File: tb/test_pwm_gen.sv
`timescale 1ns/1ps
module test_pwm_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic        trip_in;
  logic        pwm_a, pwm_b, irq, adc_soc;

  always #2 clk = ~clk;

  pwm_gen i_pwm_gen (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .trip_in,
    .pwm_a, .pwm_b, .irq, .adc_soc
  );

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";
  bit    done = 0;

  task automatic chk_bit(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", cur_req, what, act, exp);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  // Behavioural reference state
  int m_cnt, m_up, m_prd, m_ca, m_cb, s_prd, s_ca, s_cb;
  int cfg, acta, actb, red, fed, evsel, cdiv;
  int dca, dcb, ccnt;
  bit ra, rb, car, lat, m_irq, m_soc;

  function automatic bit apply_act(bit v, int act, int evm);
    for (int i = 0; i < 6; i++) begin
      if ((evm >> i) & 1) begin
        case ((act >> (2 * i)) & 3)
          1: v = 0;
          2: v = 1;
          3: v = !v;
          default: ;
        endcase
      end
    end
    return v;
  endfunction

  function automatic bit pick_ev(int sel, int evm);
    if (sel >= 1 && sel <= 6) return bit'((evm >> (sel - 1)) & 1);
    return 0;
  endfunction

  always @(posedge clk) begin
    int mode, run, evm, n_cnt, n_up;
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_prd = 0; m_ca = 0; m_cb = 0;
      s_prd = 0; s_ca = 0; s_cb = 0; cfg = 0; acta = 0; actb = 0;
      red = 0; fed = 0; evsel = 0; cdiv = 0; dca = 0; dcb = 0; ccnt = 0;
      ra = 0; rb = 0; car = 0; lat = 0; m_irq = 0; m_soc = 0;
    end else begin
      mode = cfg & 3;
      run  = (cfg >> 2) & 1;
      evm  = 0;
      if (run != 0) begin
        if (m_cnt == 0)                 evm |= 1;
        if (m_cnt == m_prd)             evm |= 2;
        if (m_cnt == m_ca && m_up != 0) evm |= 4;
        if (m_cnt == m_ca && m_up == 0) evm |= 8;
        if (m_cnt == m_cb && m_up != 0) evm |= 16;
        if (m_cnt == m_cb && m_up == 0) evm |= 32;
      end
      m_irq = pick_ev(evsel & 7, evm);
      m_soc = pick_ev((evsel >> 3) & 7, evm);
      n_cnt = m_cnt; n_up = m_up;
      if (run == 0) begin
        n_cnt = 0; n_up = (mode != 1) ? 1 : 0;
      end else if (mode == 0) begin
        n_up = 1; n_cnt = (m_cnt == m_prd) ? 0 : m_cnt + 1;
      end else if (mode == 1) begin
        n_up = 0; n_cnt = (m_cnt == 0) ? s_prd : m_cnt - 1;
      end else if (mode == 2) begin
        if (m_up != 0) begin
          if (m_cnt == m_prd) begin n_cnt = m_cnt - 1; n_up = 0; end
          else n_cnt = m_cnt + 1;
        end else if (m_cnt == 0) begin n_cnt = 1; n_up = 1; end
        else n_cnt = m_cnt - 1;
      end
      if (m_cnt == 0) begin m_prd = s_prd; m_ca = s_ca; m_cb = s_cb; end
      m_cnt = n_cnt; m_up = n_up;
      dca = ra ? ((dca < red) ? dca + 1 : dca) : 0;
      dcb = !ra ? ((dcb < fed) ? dcb + 1 : dcb) : 0;
      ra = apply_act(ra, acta, evm);
      rb = apply_act(rb, actb, evm);
      if (ccnt == cdiv) begin ccnt = 0; car = !car; end else ccnt++;
      if (trip_in && ((cfg >> 5) & 1) != 0) lat = 1;
      else if (wr_en && wr_addr == 4'd9) lat = 0;
      if (wr_en) begin
        case (wr_addr)
          4'd0: s_prd = wr_data;
          4'd1: s_ca = wr_data;
          4'd2: s_cb = wr_data;
          4'd3: cfg = wr_data & 63;
          4'd4: acta = wr_data & 4095;
          4'd5: actb = wr_data & 4095;
          4'd6: red = wr_data & 1023;
          4'd7: fed = wr_data & 1023;
          4'd8: evsel = wr_data & 63;
          4'd10: cdiv = wr_data & 255;
          default: ;
        endcase
      end
    end
    #1;
    if (!done) begin
      bit ea, eb, dben, chen, off;
      dben = ((cfg >> 3) & 1) != 0;
      chen = ((cfg >> 4) & 1) != 0;
      off  = trip_in || lat;
      ea = dben ? (ra && dca >= red) : ra;
      eb = dben ? (!ra && dcb >= fed) : rb;
      ea = ea && (!chen || car) && !off;
      eb = eb && (!chen || car) && !off;
      chk_bit(pwm_a, ea, "pwm_a vs model");
      chk_bit(pwm_b, eb, "pwm_b vs model");
      chk_bit(irq, m_irq, "irq vs model");
      chk_bit(adc_soc, m_soc, "adc_soc vs model");
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = a[3:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic irq_spacing(input int exp, input string what);
    int n = 0;
    while (!irq && n < 300) begin @(negedge clk); n++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!irq && n < 300);
    chk_int(n, exp, what);
  endtask

  task automatic high_width(input bit sel_b, input int exp, input string what);
    int n = 0;
    while ((sel_b ? pwm_b : pwm_a) && n < 300) begin @(negedge clk); n++; end
    n = 0;
    while (!(sel_b ? pwm_b : pwm_a) && n < 300) begin @(negedge clk); n++; end
    n = 0;
    while ((sel_b ? pwm_b : pwm_a) && n < 300) begin @(negedge clk); n++; end
    chk_int(n, exp, what);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL %s watchdog: actual=timeout expected=finish", cur_req);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0; trip_in = 0;
    cycles(5);
    rst_n = 1;
    cycles(3);
    // R1 reset state
    cur_req = "R1";
    chk_bit(pwm_a, 0, "pwm_a after reset");
    chk_bit(pwm_b, 0, "pwm_b after reset");
    chk_bit(irq, 0, "irq after reset");
    chk_bit(adc_soc, 0, "adc_soc after reset");

    // Up count, single edge, irq on zero, soc on compare-A up
    cur_req = "R2 R4 R11";
    wr(0, 9); wr(1, 3); wr(2, 6);
    wr(4, 2 | (1 << 4)); wr(5, 2 | (1 << 8));
    wr(8, 1 | (3 << 3));
    wr(3, 4);
    cycles(30);
    irq_spacing(10, "up-mode period");
    high_width(0, 3, "A single-edge width");
    high_width(1, 6, "B single-edge width");
    wr(3, 0); cycles(4);

    // Up-down count, symmetric
    cur_req = "R2 R4";
    wr(0, 8); wr(1, 2); wr(2, 5);
    wr(4, (2 << 4) | (1 << 6)); wr(5, (2 << 8) | (1 << 10));
    wr(8, 1);
    wr(3, 6);
    cycles(40);
    irq_spacing(16, "up-down period");
    high_width(0, 12, "A symmetric width");
    high_width(1, 6, "B symmetric width");
    wr(3, 0); cycles(4);

    // Asymmetric on A
    cur_req = "R5";
    wr(0, 12); wr(1, 2); wr(2, 7);
    wr(4, (2 << 4) | (1 << 8)); wr(5, 0);
    wr(3, 4);
    cycles(30);
    high_width(0, 5, "A asymmetric width");
    wr(3, 0); cycles(4);

    // Down count, toggle on period, irq on period
    cur_req = "R2 R3 R11";
    wr(0, 7); wr(1, 3); wr(2, 2);
    wr(4, 3 << 2); wr(5, (2 << 6) | (1 << 10));
    wr(8, 2 | (4 << 3));
    wr(3, 5);
    cycles(30);
    irq_spacing(8, "down-mode period");
    high_width(0, 8, "A toggle width");
    wr(3, 0); cycles(4);

    // Same-cycle events: compare-A up field beats zero field
    cur_req = "R3";
    wr(0, 5); wr(1, 0);
    wr(4, 2 | (1 << 4));
    wr(3, 4);
    cycles(8);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk_bit(pwm_a, 0, "priority of later field");
    end
    wr(3, 0); cycles(4);

    // Shadow load while running
    cur_req = "R6";
    wr(0, 9); wr(1, 3);
    wr(4, 2 | (1 << 4));
    wr(3, 4);
    cycles(13);
    wr(1, 6);
    high_width(0, 6, "new compare after zero");
    wr(0, 14); cycles(3); wr(1, 2);
    cycles(60);
    wr(3, 0); cycles(4);

    // Dead-band
    cur_req = "R7";
    wr(0, 19); wr(1, 10);
    wr(4, 2 | (1 << 4)); wr(6, 3); wr(7, 5);
    wr(3, 4 | 8);
    cycles(45);
    high_width(0, 7, "A after rising delay");
    high_width(1, 5, "B after falling delay");
    wr(3, 0); cycles(4);

    // Chopper
    cur_req = "R10";
    wr(10, 1);
    wr(3, 4 | 16);
    cycles(80);
    wr(10, 2);
    cycles(80);
    wr(3, 0); cycles(4);

    // Unlatched trip
    cur_req = "R8";
    wr(0, 9); wr(1, 5);
    wr(4, 2 | (1 << 4)); wr(5, 1 | (2 << 8));
    wr(3, 4);
    cycles(14);
    trip_in = 1;
    for (int i = 0; i < 12; i++) begin
      #1;
      chk_bit(pwm_a, 0, "A during trip");
      chk_bit(pwm_b, 0, "B during trip");
      @(negedge clk);
    end
    trip_in = 0;
    cycles(30);

    // Latched trip
    cur_req = "R9";
    wr(3, 4 | 32);
    cycles(5);
    trip_in = 1;
    cycles(2);
    trip_in = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk_bit(pwm_a, 0, "A held by latch");
      chk_bit(pwm_b, 0, "B held by latch");
    end
    wr(9, 0);
    begin
      int n = 0;
      while (!pwm_a && n < 40) begin @(negedge clk); n++; end
      chk_bit(pwm_a, 1, "A resumes after clear");
    end
    cycles(20);

    done = 1;
    summary();
    $finish;
  end
endmodule